// File: doc/BRIEF.md
# Prefixed immediate extension decoder

This block sits in the decode stage of a small processor whose instruction stream is made mostly of 16-bit words, with occasional 32-bit words. It sorts each accepted word into an operand class and produces a 32-bit immediate for it. One special 16-bit word, the immediate prefix, does nothing by itself. Instead it parks a 10-bit value, and the next accepted instruction places that value above its own short immediate field. A 6-bit field therefore grows to 16 bits, and a 10-bit field grows to 20 bits.

The block also expands a 4-bit constant code into the small set of constants that common instructions need. A flush input from the pipeline throws away a parked prefix and the word presented in the same cycle. Results are registered and appear one clock after the instruction is accepted.

Top module: `pfx_imm_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and no prefix is pending, so the first short-immediate instruction reports `out_ext` = 0.
- R2: When `instr_long` is 1 the class is LONG (5). Otherwise opcode bits [15:10] select the class: 00xxxx is SHORT (0), 01xxxx is WIDE (1), 10xxxx is CONST (2), 111100 is PREFIX (4), and every other 11xxxx is PLAIN (3).
- R3: With no prefix pending, SHORT reports bits [5:0] zero-extended, WIDE reports bits [9:0] zero-extended, PLAIN reports 0, and `out_ext` is 0.
- R4: With a prefix value P pending, SHORT reports {P, bits[5:0]} (16 bits) and WIDE reports {P, bits[9:0]} (20 bits), both zero-extended, with `out_ext` = 1. `out_ext` is never 1 unless a prefix was pending.
- R5: Any accepted instruction that is not a prefix consumes a pending prefix. The instruction after it is not extended.
- R6: A prefix accepted while another is pending replaces it. Only the newer bits are used, and nothing is flagged.
- R7: When `flush` is 1, the pending prefix is discarded, the word presented in that cycle is dropped, and `out_valid` is 0 in the next cycle.
- R8: CONST expands code bits [3:0]: codes 0–8 give 0–8, codes 9, 10 and 11 give 16, 24 and 32, and codes 12–15 give 0. `out_ext` is 0 and a pending prefix is consumed.
- R9: LONG reports bits [31:16] zero-extended with `out_ext` = 0, and discards any pending prefix.
- R10: `out_valid` is 1 exactly one clock after a word is accepted (`instr_valid` = 1, `flush` = 0). Idle cycles leave a pending prefix untouched.
- R11: A PREFIX word itself reports class 4 with its bits [9:0] zero-extended as the immediate and `out_ext` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_long | input | 1 | Word is a 32-bit instruction |
| instr_word | input | 32 | Instruction word; a short word uses bits [15:0] |
| flush | input | 1 | Discard the pending prefix and the current word |
| out_valid | output | 1 | Decoded result valid |
| out_class | output | 3 | Operand class code (see R2) |
| out_imm | output | 32 | Assembled immediate |
| out_ext | output | 1 | Immediate was widened by a prefix |

## Verification
The prefix register is the only state that carries from one instruction to the next. A wrong value in it never shows on the cycle the prefix arrives. It shows one result later, in the upper bits of the next SHORT or WIDE immediate and in `out_ext`. A prefix that fails to clear shows up as a spurious extension on the second instruction after the prefix, or after a flush. Bit slips in the join show up at once as wrong bits at positions 6 and 10 of `out_imm`.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int WORD_W     = 32;
  localparam int OPC_W      = 6;
  localparam int OPC_LSB    = 10;
  localparam int PFX_W      = 10;
  localparam int NARROW_W   = 6;
  localparam int WIDE_W     = 10;
  localparam int CODE_W     = 4;
  localparam int LONG_W     = 16;
  localparam int LONG_LSB   = 16;
  localparam int IMM_W      = 32;
  localparam logic [OPC_W-1:0] PFX_OPC = 6'b111100;

  typedef enum logic [2:0] {
    CL_SHORT  = 3'd0,
    CL_WIDE   = 3'd1,
    CL_CONST  = 3'd2,
    CL_PLAIN  = 3'd3,
    CL_PREFIX = 3'd4,
    CL_LONG   = 3'd5
  } op_class_e;
endpackage

// File: rtl/pfx_rst_sync.sv
module pfx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pfx_field_split.sv
module pfx_field_split
  import pfx_pkg::*;
#(
  parameter int W_WORD   = WORD_W,
  parameter int W_OPC    = OPC_W,
  parameter int OPC_BASE = OPC_LSB,
  parameter int W_NARROW = NARROW_W,
  parameter int W_WIDE   = WIDE_W,
  parameter int W_CODE   = CODE_W,
  parameter int W_LONG   = LONG_W,
  parameter int LONG_BASE = LONG_LSB,
  parameter logic [W_OPC-1:0] PREFIX_OPC = PFX_OPC
) (
  input  logic [W_WORD-1:0]   word,
  input  logic                is_long,
  output op_class_e           cls,
  output logic [W_NARROW-1:0] narrow_fld,
  output logic [W_WIDE-1:0]   wide_fld,
  output logic [W_CODE-1:0]   code_fld,
  output logic [W_LONG-1:0]   long_fld
);
  logic [W_OPC-1:0] opc;
  logic [1:0]       grp;

  assign opc        = word[OPC_BASE +: W_OPC];
  assign grp        = opc[W_OPC-1 -: 2];
  assign narrow_fld = word[W_NARROW-1:0];
  assign wide_fld   = word[W_WIDE-1:0];
  assign code_fld   = word[W_CODE-1:0];
  assign long_fld   = word[LONG_BASE +: W_LONG];

  always_comb begin
    if (is_long) begin
      cls = CL_LONG;
    end else begin
      unique case (grp)
        2'b00:   cls = CL_SHORT;
        2'b01:   cls = CL_WIDE;
        2'b10:   cls = CL_CONST;
        default: cls = (opc == PREFIX_OPC) ? CL_PREFIX : CL_PLAIN;
      endcase
    end
  end
endmodule

// File: rtl/pfx_const_expand.sv
module pfx_const_expand
  import pfx_pkg::*;
#(
  parameter int W_CODE     = CODE_W,
  parameter int W_IMM      = IMM_W,
  parameter int DIRECT_MAX = 8,
  parameter int STEP_LAST  = 11,
  parameter int STEP_SHIFT = 3
) (
  input  logic [W_CODE-1:0] code,
  output logic [W_IMM-1:0]  value
);
  localparam int STEP_BIAS = DIRECT_MAX - 1;

  logic [W_IMM-1:0] code_wide;
  assign code_wide = W_IMM'(code);

  always_comb begin
    if (code_wide <= W_IMM'(DIRECT_MAX)) begin
      value = code_wide;
    end else if (code_wide <= W_IMM'(STEP_LAST)) begin
      value = (code_wide - W_IMM'(STEP_BIAS)) << STEP_SHIFT;
    end else begin
      value = '0;
    end
  end
endmodule

// File: rtl/pfx_hold.sv
module pfx_hold #(
  parameter int W_PFX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             accept,
  input  logic             is_prefix,
  input  logic [W_PFX-1:0] pfx_in,
  output logic             pend_valid,
  output logic [W_PFX-1:0] pend_bits
);
  logic             valid_d;
  logic [W_PFX-1:0] bits_d;
  logic             bits_en;

  always_comb begin
    valid_d = pend_valid;
    bits_en = 1'b0;
    bits_d  = pfx_in;
    if (flush) begin
      valid_d = 1'b0;
    end else if (accept) begin
      valid_d = is_prefix;
      bits_en = is_prefix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_bits  <= '0;
    end else begin
      pend_valid <= valid_d;
      if (bits_en) pend_bits <= bits_d;
    end
  end
endmodule

// File: rtl/pfx_merge.sv
module pfx_merge
  import pfx_pkg::*;
#(
  parameter int W_PFX    = PFX_W,
  parameter int W_NARROW = NARROW_W,
  parameter int W_WIDE   = WIDE_W,
  parameter int W_LONG   = LONG_W,
  parameter int W_IMM    = IMM_W
) (
  input  op_class_e           cls,
  input  logic [W_NARROW-1:0] narrow_fld,
  input  logic [W_WIDE-1:0]   wide_fld,
  input  logic [W_LONG-1:0]   long_fld,
  input  logic [W_IMM-1:0]    const_val,
  input  logic                pend_valid,
  input  logic [W_PFX-1:0]    pend_bits,
  output logic [W_IMM-1:0]    imm,
  output logic                ext
);
  localparam int NARROW_EXT_W = W_PFX + W_NARROW;
  localparam int WIDE_EXT_W   = W_PFX + W_WIDE;

  logic [NARROW_EXT_W-1:0] narrow_joined;
  logic [WIDE_EXT_W-1:0]   wide_joined;

  assign narrow_joined = {pend_bits, narrow_fld};
  assign wide_joined   = {pend_bits, wide_fld};

  always_comb begin
    imm = '0;
    ext = 1'b0;
    unique case (cls)
      CL_SHORT: begin
        if (pend_valid) begin
          imm[NARROW_EXT_W-1:0] = narrow_joined;
          ext = 1'b1;
        end else begin
          imm[W_NARROW-1:0] = narrow_fld;
        end
      end
      CL_WIDE: begin
        if (pend_valid) begin
          imm[WIDE_EXT_W-1:0] = wide_joined;
          ext = 1'b1;
        end else begin
          imm[W_WIDE-1:0] = wide_fld;
        end
      end
      CL_CONST:  imm = const_val;
      CL_PREFIX: imm[W_WIDE-1:0] = wide_fld;
      CL_LONG:   imm[W_LONG-1:0] = long_fld;
      default:   imm = '0;
    endcase
  end
endmodule

// File: rtl/pfx_imm_decoder.sv
module pfx_imm_decoder
  import pfx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              instr_long,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              flush,
  output logic              out_valid,
  output logic [2:0]        out_class,
  output logic [IMM_W-1:0]  out_imm,
  output logic              out_ext
);
  logic                rst_sync_n;
  op_class_e           cls;
  logic [NARROW_W-1:0] narrow_fld;
  logic [WIDE_W-1:0]   wide_fld;
  logic [CODE_W-1:0]   code_fld;
  logic [LONG_W-1:0]   long_fld;
  logic [IMM_W-1:0]    const_val;
  logic                pend_valid;
  logic [PFX_W-1:0]    pend_bits;
  logic [IMM_W-1:0]    imm_d;
  logic                ext_d;
  logic                accept;

  assign accept = instr_valid & ~flush;

  pfx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pfx_field_split u_split (
    .word       (instr_word),
    .is_long    (instr_long),
    .cls        (cls),
    .narrow_fld (narrow_fld),
    .wide_fld   (wide_fld),
    .code_fld   (code_fld),
    .long_fld   (long_fld)
  );

  pfx_const_expand u_const (
    .code  (code_fld),
    .value (const_val)
  );

  pfx_hold #(.W_PFX(PFX_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush      (flush),
    .accept     (accept),
    .is_prefix  (cls == CL_PREFIX),
    .pfx_in     (wide_fld),
    .pend_valid (pend_valid),
    .pend_bits  (pend_bits)
  );

  pfx_merge u_merge (
    .cls        (cls),
    .narrow_fld (narrow_fld),
    .wide_fld   (wide_fld),
    .long_fld   (long_fld),
    .const_val  (const_val),
    .pend_valid (pend_valid),
    .pend_bits  (pend_bits),
    .imm        (imm_d),
    .ext        (ext_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_class <= '0;
      out_imm   <= '0;
      out_ext   <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_class <= cls;
        out_imm   <= imm_d;
        out_ext   <= ext_d;
      end
    end
  end
endmodule

// File: rtl/pfx_imm_decoder_chk.sv
module pfx_imm_decoder_chk
  import pfx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_long,
  input logic [WORD_W-1:0] instr_word,
  input logic              flush,
  input logic              out_valid,
  input logic [2:0]        out_class,
  input logic [IMM_W-1:0]  out_imm,
  input logic              out_ext,
  input logic              pend_valid
);
  logic in_is_pfx;
  assign in_is_pfx = !instr_long && (instr_word[OPC_LSB +: OPC_W] == PFX_OPC);

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !flush) |=> out_valid); // R10

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid || flush) |=> !out_valid); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_valid); // R7

  AST_PFX_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !flush && !in_is_pfx) |=> !pend_valid); // R5

  AST_EXT_NEEDS_PFX: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !flush && !pend_valid) |=> !out_ext); // R4

  AST_CONST_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'(CL_CONST)) |-> (out_imm <= 32 && !out_ext)); // R8

  AST_LONG_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'(CL_LONG)) |-> (!out_ext && out_imm[IMM_W-1:LONG_W] == '0)); // R9

  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class <= 3'(CL_LONG))); // R2
endmodule

bind pfx_imm_decoder pfx_imm_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .instr_valid (instr_valid),
  .instr_long  (instr_long),
  .instr_word  (instr_word),
  .flush       (flush),
  .out_valid   (out_valid),
  .out_class   (out_class),
  .out_imm     (out_imm),
  .out_ext     (out_ext),
  .pend_valid  (pend_valid)
);

// File: tb/pfx_imm_decoder_test.sv
module pfx_imm_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam int RAND_STEPS = 3000;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic        instr_long;
  logic [31:0] instr_word;
  logic        flush;
  logic        out_valid;
  logic [2:0]  out_class;
  logic [31:0] out_imm;
  logic        out_ext;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic       m_pend;
  logic [9:0] m_bits;

  pfx_imm_decoder uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_long(instr_long),
    .instr_word(instr_word), .flush(flush), .out_valid(out_valid),
    .out_class(out_class), .out_imm(out_imm), .out_ext(out_ext)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] exp_class(logic [31:0] w, logic lng);
    if (lng) return 3'd5;
    case (w[15:14])
      2'b00: return 3'd0;
      2'b01: return 3'd1;
      2'b10: return 3'd2;
      default: return (w[15:10] == 6'b111100) ? 3'd4 : 3'd3;
    endcase
  endfunction

  function automatic logic [31:0] exp_const(logic [3:0] c);
    case (c)
      4'd9:  return 32'd16;
      4'd10: return 32'd24;
      4'd11: return 32'd32;
      default: return (c <= 4'd8) ? {28'd0, c} : 32'd0;
    endcase
  endfunction

  function automatic logic [32:0] exp_result(logic [31:0] w, logic lng, logic pv, logic [9:0] pb);
    case (exp_class(w, lng))
      3'd0: return pv ? {1'b1, 16'd0, pb, w[5:0]} : {1'b0, 26'd0, w[5:0]};
      3'd1: return pv ? {1'b1, 12'd0, pb, w[9:0]} : {1'b0, 22'd0, w[9:0]};
      3'd2: return {1'b0, exp_const(w[3:0])};
      3'd4: return {1'b0, 22'd0, w[9:0]};
      3'd5: return {1'b0, 16'd0, w[31:16]};
      default: return 33'd0;
    endcase
  endfunction

  task automatic step(input logic v, input logic lng, input logic [31:0] w,
                      input logic fl, input string tag);
    logic        e_valid;
    logic [2:0]  e_cls;
    logic [32:0] e_res;
    @(negedge clk);
    instr_valid = v; instr_long = lng; instr_word = w; flush = fl;
    e_valid = v && !fl;
    e_cls   = exp_class(w, lng);
    e_res   = exp_result(w, lng, m_pend, m_bits);
    @(posedge clk);
    #1;
    checks++;
    if (e_valid) begin
      if (!out_valid || out_class !== e_cls || out_imm !== e_res[31:0] || out_ext !== e_res[32]) begin
        fails++;
        $display("FAIL %s: got v=%0d cls=%0d imm=%h ext=%0d, expected v=1 cls=%0d imm=%h ext=%0d",
                 tag, out_valid, out_class, out_imm, out_ext, e_cls, e_res[31:0], e_res[32]);
      end
    end else if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s: got out_valid=%0d, expected 0", tag, out_valid);
    end
    if (fl) m_pend = 1'b0;
    else if (v) begin
      m_pend = (e_cls == 3'd4);
      if (e_cls == 3'd4) m_bits = w[9:0];
    end
  endtask

  function automatic logic [31:0] pfx_word(logic [9:0] b);
    return {16'd0, 6'b111100, b};
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; instr_valid = 1'b0; instr_long = 1'b0; instr_word = '0; flush = 1'b0;
    m_pend = 1'b0; m_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got out_valid=%0d, expected 0", out_valid);
    end
    step(1, 0, 32'h0000_002A, 0, "R1 first short unextended");
    step(1, 0, 32'h0000_4155, 0, "R3 wide plain");
    step(1, 0, 32'h0000_C000, 0, "R2 plain class");
    step(1, 0, pfx_word(10'h3FF), 0, "R11 prefix result");
    step(1, 0, 32'h0000_002A, 0, "R4 short joined");
    step(1, 0, 32'h0000_0011, 0, "R5 no reuse");
    step(1, 0, pfx_word(10'h155), 0, "R11 prefix");
    step(1, 0, 32'h0000_43FF, 0, "R4 wide joined");
    step(1, 0, pfx_word(10'h001), 0, "R6 first prefix");
    step(1, 0, pfx_word(10'h2AA), 0, "R6 second prefix");
    step(1, 0, 32'h0000_0005, 0, "R6 newer wins");
    step(1, 0, pfx_word(10'h0F0), 0, "R10 prefix");
    step(0, 0, 32'hFFFF_FFFF, 0, "R10 idle");
    step(0, 0, 32'h0, 0, "R10 idle");
    step(1, 0, 32'h0000_0001, 0, "R10 prefix kept over idle");
    step(1, 0, pfx_word(10'h3C3), 0, "R7 prefix");
    step(1, 0, 32'h0000_0009, 1, "R7 flushed word dropped");
    step(1, 0, 32'h0000_0009, 0, "R7 prefix gone");
    step(1, 0, pfx_word(10'h111), 0, "R7 prefix");
    step(0, 0, 32'h0, 1, "R7 bare flush");
    step(1, 0, 32'h0000_4001, 0, "R7 prefix gone after bare flush");
    for (int c = 0; c < 16; c++) step(1, 0, 32'h0000_8000 | c, 0, "R8 constant code");
    step(1, 0, pfx_word(10'h3FF), 0, "R8 prefix");
    step(1, 0, 32'h0000_800B, 0, "R8 constant ignores prefix");
    step(1, 0, 32'h0000_0003, 0, "R8 prefix consumed");
    step(1, 0, pfx_word(10'h0AB), 0, "R9 prefix");
    step(1, 1, 32'hBEEF_3C12, 0, "R9 long");
    step(1, 0, 32'h0000_0003, 0, "R9 prefix discarded");
    step(1, 0, pfx_word(10'h0AB), 0, "R5 prefix");
    step(1, 0, 32'h0000_C7FF, 0, "R5 plain consumes");
    step(1, 0, 32'h0000_0003, 0, "R5 after plain");
    for (int i = 0; i < RAND_STEPS; i++) begin
      logic [31:0] w;
      int          sel;
      logic        v, fl, lng;
      w   = $urandom;
      sel = int'($urandom_range(0, 9));
      if (sel < 3) w[15:10] = 6'b111100;
      v   = ($urandom_range(0, 99) < 85);
      fl  = ($urandom_range(0, 99) < 5);
      lng = ($urandom_range(0, 99) < 10);
      step(v, lng, w, fl, "R2 R3 R4 R5 R6 R8 random mix");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule